// File: doc/BRIEF.md
# Mailbox Transmit Inbox

This block is the sending side of a mailbox between processors, with registers on a bus. A host writes the low and high 32-bit halves of a 64-bit message and writes a destination channel number. It then writes the trigger register. The block moves the message into a holding slot for that channel and marks the channel busy.

A destination core collects the message through a fetch port. It gives a channel index and a one-cycle strobe. The port returns the stored message. The collection clears that channel's busy flag and sets its delivered flag.

A trigger aimed at a channel that is still busy does not replace the held message. It sets that channel's overflow flag instead. Delivered and overflow flags stay set until the host writes a clear mask. A single interrupt line latches whenever an enabled source is active. The host clears it by writing to the interrupt status register.

Top module: `mbox_tx_inbox`

## Requirements
- R1: After reset the status word (offset 0x14) reads 0, the interrupt mask (offset 0x1C) reads 3'b111, the interrupt status (offset 0x18) reads 0 and `irq` is low.
- R2: Writes to offset 0x00 (channel number, 3 bits), 0x04 (message bits 31:0) and 0x08 (message bits 63:32) are held and read back at the same offsets. Unused bits read as 0.
- R3: A write to offset 0x0C with bit 0 set, when the channel named at 0x00 is not busy, sets that channel's busy bit. It also stores the staged 64-bit message in that channel's slot. A write with bit 0 clear does nothing.
- R4: With `fetch_stb` high, `fetch_data` shows the slot of `fetch_chan` in the same cycle. If that channel is busy, the next cycle has its busy bit clear and its delivered bit set. Fetching an idle channel changes no flag.
- R5: A trigger aimed at a busy channel sets that channel's overflow bit. The busy bit stays set and the held message is unchanged.
- R6: Status word layout: bits 23:16 are the delivered flags, bits 15:8 the overflow flags and bits 7:0 the busy flags, with channel n at the low bit plus n. Bits 31:24 read 0.
- R7: A write to offset 0x10 clears every delivered flag and every overflow flag whose bit is 1 in the written value, using the R6 positions. A delivered flag set by a fetch in the same cycle stays set.
- R8: Interrupt mask bits at offset 0x1C are: bit 0 blocked, bit 1 overflow, bit 2 delivered, where 1 disables the source. The blocked source is a trigger that hits a busy channel. The overflow source is any overflow flag set. The delivered source is any delivered flag set. Any enabled source sets the pending bit, which is bit 0 of offset 0x18 and drives `irq`.
- R9: Writing 1 to bit 0 of offset 0x18 clears the pending bit. A source active in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read byte offset |
| rd_data | output | 32 | Register read data, combinational |
| fetch_stb | input | 1 | Remote fetch strobe |
| fetch_chan | input | 3 | Channel being fetched |
| fetch_data | output | 64 | Message held for `fetch_chan` |
| irq | output | 1 | Latched interrupt |

## Verification
The bench fires a second trigger at a busy channel and checks both the overflow flag and the held message. A design that overwrote the slot would give the remote core the newer message and lose the first one.

It fetches idle channels and checks that no delivered flag appears. A design that got this wrong would report a delivery that never happened.

It writes the clear mask in the same cycle as a fetch, and clears the interrupt while a source is still active. A design that let the clear win would drop a delivery or an interrupt.

A random sequence of triggers, fetches, clears and mask changes is checked every cycle against a bench model. This catches wrong bit positions in the status word and masking of the wrong source.

// File: rtl/mbox_tx_inbox.sv
module mbox_tx_inbox #(
  parameter int NCH = 8,
  parameter int AW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          fetch_stb,
  input  logic [$clog2(NCH)-1:0] fetch_chan,
  output logic [63:0]   fetch_data,
  output logic          irq
);
  localparam int CW = $clog2(NCH);
  localparam logic [AW-1:0] A_ID = 'h00, A_LO = 'h04, A_HI = 'h08, A_TRIG = 'h0C,
                            A_CLR = 'h10, A_STS = 'h14, A_IST = 'h18, A_MSK = 'h1C;

  logic [CW-1:0]  tid;
  logic [31:0]    lo, hi;
  logic [NCH-1:0] busy, ovf, dlv;
  logic [2:0]     mask;
  logic           pend;
  logic [63:0]    slot [NCH];

  logic trig, blk, clr_wr, ist_clr, src_any;
  logic [NCH-1:0] busy_n, ovf_n, dlv_n;

  assign trig    = wr_en && wr_addr == A_TRIG && wr_data[0];
  assign blk     = trig && busy[tid];
  assign clr_wr  = wr_en && wr_addr == A_CLR;
  assign ist_clr = wr_en && wr_addr == A_IST && wr_data[0];
  assign src_any = (|dlv && !mask[2]) || (|ovf && !mask[1]) || (blk && !mask[0]);
  assign fetch_data = slot[fetch_chan];
  assign irq = pend;

  always_comb begin
    busy_n = busy;
    ovf_n  = ovf;
    dlv_n  = dlv;
    if (clr_wr) begin
      dlv_n = dlv_n & ~wr_data[16 +: NCH];
      ovf_n = ovf_n & ~wr_data[8 +: NCH];
    end
    if (fetch_stb && busy[fetch_chan]) begin
      busy_n[fetch_chan] = 1'b0;
      dlv_n[fetch_chan]  = 1'b1;
    end
    if (trig) begin
      if (busy[tid]) ovf_n[tid] = 1'b1;
      else           busy_n[tid] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tid  <= '0;
      lo   <= '0;
      hi   <= '0;
      busy <= '0;
      ovf  <= '0;
      dlv  <= '0;
      mask <= 3'b111;
      pend <= 1'b0;
    end else begin
      busy <= busy_n;
      ovf  <= ovf_n;
      dlv  <= dlv_n;
      pend <= src_any || (pend && !ist_clr);
      if (wr_en) begin
        case (wr_addr)
          A_ID:  tid  <= wr_data[CW-1:0];
          A_LO:  lo   <= wr_data;
          A_HI:  hi   <= wr_data;
          A_MSK: mask <= wr_data[2:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[c] <= '0;
      else if (trig && !busy[tid] && tid == c) slot[c] <= {hi, lo};
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_ID:  rd_data[CW-1:0] = tid;
      A_LO:  rd_data = lo;
      A_HI:  rd_data = hi;
      A_STS: begin
        rd_data[16 +: NCH] = dlv;
        rd_data[8 +: NCH]  = ovf;
        rd_data[0 +: NCH]  = busy;
      end
      A_IST: rd_data[0] = pend;
      A_MSK: rd_data[2:0] = mask;
      default: ;
    endcase
  end
endmodule

module mbox_tx_inbox_chk #(
  parameter int NCH = 8
) (
  input logic clk,
  input logic rst_n,
  input logic trig,
  input logic [$clog2(NCH)-1:0] tid,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] ovf,
  input logic [NCH-1:0] dlv,
  input logic fetch_stb,
  input logic [$clog2(NCH)-1:0] fetch_chan,
  input logic [63:0] fetch_data,
  input logic src_any,
  input logic ist_clr,
  input logic irq
);
  assert_busy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !busy[tid] |=> busy[$past(tid)]);
  assert_fetch_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb && busy[fetch_chan] |=> !busy[$past(fetch_chan)] && dlv[$past(fetch_chan)]);
  assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig && busy[tid] && !(fetch_stb && fetch_chan == tid)
      |=> ovf[$past(tid)] && busy[$past(tid)]);
  assert_slot_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig && busy[tid] && fetch_stb && fetch_chan == tid |=> $stable(fetch_data) || fetch_chan != $past(fetch_chan));
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(src_any));
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && ist_clr && !src_any |=> !irq);
endmodule

bind mbox_tx_inbox mbox_tx_inbox_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .tid(tid), .busy(busy), .ovf(ovf),
  .dlv(dlv), .fetch_stb(fetch_stb), .fetch_chan(fetch_chan),
  .fetch_data(fetch_data), .src_any(src_any), .ist_clr(ist_clr), .irq(irq)
);

// File: tb/tb_mbox_tx_inbox.sv
`timescale 1ns/1ps
module tb_mbox_tx_inbox;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic fetch_stb = 0;
  logic [2:0] fetch_chan = 0;
  logic [63:0] fetch_data;
  logic irq;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [2:0] m_id; logic [31:0] m_lo, m_hi;
  logic [7:0] m_busy, m_ovf, m_dlv; logic [2:0] m_mask; logic m_pend;
  logic [63:0] m_slot [8];

  mbox_tx_inbox dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_sts();
    return {8'h00, m_dlv, m_ovf, m_busy};
  endfunction

  task automatic model_reset();
    m_id = 0; m_lo = 0; m_hi = 0; m_busy = 0; m_ovf = 0; m_dlv = 0;
    m_mask = 3'b111; m_pend = 0;
    for (int i = 0; i < 8; i++) m_slot[i] = 0;
  endtask

  task automatic model_step(logic we, logic [5:0] a, logic [31:0] d, logic fs, logic [2:0] fc);
    logic trig, blk, src;
    logic [7:0] nb, no, nd;
    trig = we && a == 6'h0C && d[0];
    blk = trig && m_busy[m_id];
    src = (|m_dlv && !m_mask[2]) || (|m_ovf && !m_mask[1]) || (blk && !m_mask[0]);
    nb = m_busy; no = m_ovf; nd = m_dlv;
    if (we && a == 6'h10) begin nd &= ~d[23:16]; no &= ~d[15:8]; end
    if (fs && m_busy[fc]) begin nb[fc] = 0; nd[fc] = 1; end
    if (trig) begin
      if (m_busy[m_id]) no[m_id] = 1;
      else begin nb[m_id] = 1; m_slot[m_id] = {m_hi, m_lo}; end
    end
    m_pend = src || (m_pend && !(we && a == 6'h18 && d[0]));
    m_busy = nb; m_ovf = no; m_dlv = nd;
    if (we) case (a)
      6'h00: m_id = d[2:0];
      6'h04: m_lo = d;
      6'h08: m_hi = d;
      6'h1C: m_mask = d[2:0];
      default: ;
    endcase
  endtask

  task automatic cyc(logic we, logic [5:0] a, logic [31:0] d, logic fs, logic [2:0] fc);
    wr_en = we; wr_addr = a; wr_data = d; fetch_stb = fs; fetch_chan = fc;
    #1;
    if (fs) chk("R4 fetch_data", fetch_data, m_slot[fc]);
    @(posedge clk);
    model_step(we, a, d, fs, fc);
    @(negedge clk);
    wr_en = 0; fetch_stb = 0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic send(logic [2:0] ch, logic [63:0] msg);
    cyc(1, 6'h04, msg[31:0], 0, 0);
    cyc(1, 6'h08, msg[63:32], 0, 0);
    cyc(1, 6'h00, {29'b0, ch}, 0, 0);
    cyc(1, 6'h0C, 32'h1, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_chk("R1 status", 6'h14, 0);
    rd_chk("R1 mask", 6'h1C, 32'h7);
    rd_chk("R1 intsts", 6'h18, 0);
    chk("R1 irq", irq, 0);

    cyc(1, 6'h04, 32'hdeadbeef, 0, 0);
    cyc(1, 6'h08, 32'h01234567, 0, 0);
    cyc(1, 6'h00, 32'hffff_fffd, 0, 0);
    rd_chk("R2 lo", 6'h04, 32'hdeadbeef);
    rd_chk("R2 hi", 6'h08, 32'h01234567);
    rd_chk("R2 id", 6'h00, 32'h5);

    cyc(1, 6'h0C, 32'h2, 0, 0);
    rd_chk("R3 trigger bit0 clear", 6'h14, 0);
    cyc(1, 6'h0C, 32'h1, 0, 0);
    rd_chk("R3 R6 busy ch5", 6'h14, 32'h0000_0020);

    cyc(0, 0, 0, 1, 3'd2);
    rd_chk("R4 idle fetch", 6'h14, 32'h0000_0020);

    send(3'd5, 64'h1111_2222_3333_4444);
    rd_chk("R5 R6 overflow ch5", 6'h14, 32'h0000_2020);
    cyc(0, 0, 0, 1, 3'd5);
    chk("R5 slot kept", m_slot[5], 64'h01234567_deadbeef);
    rd_chk("R4 R6 delivered ch5", 6'h14, 32'h0020_2000);

    cyc(1, 6'h10, 32'h0000_2000, 0, 0);
    rd_chk("R7 clear overflow", 6'h14, 32'h0020_0000);
    chk("R8 masked no irq", irq, 0);

    cyc(1, 6'h1C, 32'h3, 0, 0);
    @(negedge clk); model_step(0, 0, 0, 0, 0);
    chk("R8 delivered irq", irq, 1);
    cyc(1, 6'h18, 32'h1, 0, 0);
    chk("R9 clear while source active", irq, 1);
    cyc(1, 6'h10, 32'h00ff_0000, 0, 0);
    cyc(1, 6'h18, 32'h1, 0, 0);
    chk("R9 irq cleared", irq, 0);

    send(3'd1, 64'haaaa_bbbb_cccc_dddd);
    cyc(1, 6'h10, 32'h0000_0200, 1, 3'd1);
    rd_chk("R7 fetch beats clear", 6'h14, 32'h0002_0000);

    cyc(1, 6'h1C, 32'h6, 0, 0);
    cyc(1, 6'h10, 32'h00ff_ff00, 0, 0);
    cyc(1, 6'h18, 32'h1, 0, 0);
    chk("R8 idle irq", irq, 0);
    send(3'd3, 64'h5);
    cyc(1, 6'h0C, 32'h1, 0, 0);
    chk("R8 blocked irq", irq, 1);

    for (int n = 0; n < 1500; n++) begin
      int op;
      logic [31:0] r;
      op = $urandom_range(0, 9);
      r = $urandom;
      case (op)
        0: cyc(1, 6'h00, r, $urandom_range(0,1), 3'($urandom));
        1: cyc(1, 6'h04, r, 0, 0);
        2: cyc(1, 6'h08, r, 0, 0);
        3, 4: cyc(1, 6'h0C, {31'b0, r[0] | r[1]}, $urandom_range(0,1), 3'($urandom));
        5, 6: cyc(0, 0, 0, 1, 3'($urandom));
        7: cyc(1, 6'h10, r, $urandom_range(0,1), 3'($urandom));
        8: cyc(1, 6'h18, r, 0, 0);
        default: cyc(1, 6'h1C, r, 0, 0);
      endcase
      rd_chk("R6 random status", 6'h14, exp_sts());
      chk("R8 R9 random irq", irq, m_pend);
      if (n % 50 == 0) begin
        rd_chk("R2 random id", 6'h00, {29'b0, m_id});
        rd_chk("R8 random mask", 6'h1C, {29'b0, m_mask});
      end
    end
    finish_run();
  end
endmodule